// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the 32-bit address of a memory operand from a decoded operand description. It takes an optional base register value, an optional index register value, a two-bit scale code and a displacement of selectable width, and produces `displacement + base + scale * index` in a single registered stage. Every memory operand shape falls out as a special case of that one sum: displacement only (absolute), base only (indirect), base plus displacement, base plus index, and the full scaled form with or without a base.

The same sum also serves the address-only operation. In that case the result is marked as a value to be written to a register, and no memory request is raised. The computation is identical, so a shape such as `7 + x + 8x` yields `9x + 7` as an arithmetic result. The block sits between the operand decoder and the load/store path. It does not parse instruction bytes and does not access memory.

Top module: `ea_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released with no request, `out_valid`, `out_mem_req` and `out_reg_wr` are 0 and `out_addr` is 0.
- R2: A request presented with `in_valid`=1 at a rising edge appears with `out_valid`=1 exactly one cycle later. A cycle with `in_valid`=0 gives `out_valid`=0 one cycle later.
- R3: The address is the displacement plus the base plus the scaled index, added as 32-bit unsigned values.
- R4: `scale_code` selects the index multiplier: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R5: `disp_size` selects the displacement. 00 gives zero. 01 gives bits 7:0 sign-extended. 10 gives bits 15:0 sign-extended. 11 gives all 32 bits. Bits above the selected width are ignored.
- R6: When `has_base`=0 the base contributes zero, and when `has_index`=0 the index contributes zero, whatever values are on `base_val` and `index_val`.
- R7: With `lea_mode`=1 the valid result has `out_reg_wr`=1 and `out_mem_req`=0. With `lea_mode`=0 it has `out_mem_req`=1 and `out_reg_wr`=0. Both are 0 whenever `out_valid`=0.
- R8: A cycle without a request leaves `out_addr` unchanged.
- R9: The sum wraps modulo 2^32 and gives no overflow indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand description present this cycle |
| has_base | input | 1 | Base register is part of the operand |
| base_val | input | 32 | Base register value |
| has_index | input | 1 | Index register is part of the operand |
| index_val | input | 32 | Index register value |
| scale_code | input | 2 | Index multiplier as a shift amount (00=1, 01=2, 10=4, 11=8) |
| disp_raw | input | 32 | Displacement bits as fetched |
| disp_size | input | 2 | Displacement width (00 none, 01 byte, 10 halfword, 11 word) |
| lea_mode | input | 1 | Result is an arithmetic value for a register, not a memory address |
| out_valid | output | 1 | Result valid |
| out_addr | output | 32 | Computed address |
| out_mem_req | output | 1 | Valid result is a memory access address |
| out_reg_wr | output | 1 | Valid result is to be written to a register |

## Verification
All results (`out_addr`, `out_valid`, `out_mem_req`, `out_reg_wr`) are due one rising edge after the request is sampled. The bench drives each request on a falling edge and holds it across exactly one rising edge. It then deasserts `in_valid` on the next falling edge and samples all outputs at that same falling edge, which lies half a period after the edge that registered them. The hold check samples one cycle later, after an idle edge has passed, so it observes that the address did not move while `out_valid` fell.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int ADDR_W   = 32;
    localparam int NARROW_W = 8;
    localparam int MID_W    = 16;
    localparam int SCALE_W  = 2;

    typedef enum logic [1:0] {
        DISP_NONE = 2'b00,
        DISP_B8   = 2'b01,
        DISP_B16  = 2'b10,
        DISP_B32  = 2'b11
    } disp_sel_e;

    typedef enum logic [1:0] {
        SCL_X1 = 2'b00,
        SCL_X2 = 2'b01,
        SCL_X4 = 2'b10,
        SCL_X8 = 2'b11
    } scale_sel_e;

    typedef struct packed {
        logic              valid;
        logic              lea;
        logic [ADDR_W-1:0] addr;
    } ea_stage_t;

endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
    parameter int AW  = 32,
    parameter int NW  = 8,
    parameter int MW  = 16
) (
    input  logic [AW-1:0] raw,
    input  logic [1:0]    size,
    output logic [AW-1:0] disp
);
    import ea_pkg::*;

    logic [AW-1:0] ext_narrow;
    logic [AW-1:0] ext_mid;

    // Sign extension of each short field to the full operand width.
    assign ext_narrow = {{(AW-NW){raw[NW-1]}}, raw[NW-1:0]};
    assign ext_mid    = {{(AW-MW){raw[MW-1]}}, raw[MW-1:0]};

    always_comb begin
        case (disp_sel_e'(size))
            DISP_NONE: disp = '0;
            DISP_B8:   disp = ext_narrow;
            DISP_B16:  disp = ext_mid;
            default:   disp = raw;
        endcase
    end

endmodule

// File: rtl/ea_index_scale.sv
module ea_index_scale #(
    parameter int AW = 32,
    parameter int SW = 2
) (
    input  logic [AW-1:0] index,
    input  logic          present,
    input  logic [SW-1:0] code,
    output logic [AW-1:0] scaled
);
    localparam int NSCALE = 1 << SW;

    logic [AW-1:0] gated;
    logic [AW-1:0] cand [NSCALE];

    // An absent index contributes nothing, whatever sits on the bus.
    assign gated = present ? index : '0;

    // One candidate per shift amount; the code picks one of them.
    for (genvar s = 0; s < NSCALE; s++) begin : g_shift
        if (s == 0) begin : g_id
            assign cand[s] = gated;
        end else begin : g_sh
            assign cand[s] = {gated[AW-1-s:0], {s{1'b0}}};
        end
    end

    assign scaled = cand[code];

endmodule

// File: rtl/ea_sum.sv
module ea_sum #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] disp,
    input  logic [AW-1:0] base,
    input  logic          base_present,
    input  logic [AW-1:0] scaled_index,
    output logic [AW-1:0] sum
);
    logic [AW-1:0] base_g;
    logic [AW-1:0] part;

    assign base_g = base_present ? base : '0;
    assign part   = disp + base_g;
    // Carry out of the top bit is dropped: modulo 2^AW.
    assign sum    = part + scaled_index;

endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
    parameter int AW = ea_pkg::ADDR_W,
    parameter int SW = ea_pkg::SCALE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          has_base,
    input  logic [AW-1:0] base_val,
    input  logic          has_index,
    input  logic [AW-1:0] index_val,
    input  logic [SW-1:0] scale_code,
    input  logic [AW-1:0] disp_raw,
    input  logic [1:0]    disp_size,
    input  logic          lea_mode,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic          out_mem_req,
    output logic          out_reg_wr
);
    import ea_pkg::*;

    typedef struct packed {
        logic          valid;
        logic          lea;
        logic [AW-1:0] addr;
    } stage_t;

    logic [AW-1:0] disp_w;
    logic [AW-1:0] sidx_w;
    logic [AW-1:0] sum_w;

    stage_t st_d;
    stage_t st_q;

    ea_disp_ext #(
        .AW (AW),
        .NW (NARROW_W),
        .MW (MID_W)
    ) u_disp (
        .raw  (disp_raw),
        .size (disp_size),
        .disp (disp_w)
    );

    ea_index_scale #(
        .AW (AW),
        .SW (SW)
    ) u_scale (
        .index   (index_val),
        .present (has_index),
        .code    (scale_code),
        .scaled  (sidx_w)
    );

    ea_sum #(
        .AW (AW)
    ) u_sum (
        .disp         (disp_w),
        .base         (base_val),
        .base_present (has_base),
        .scaled_index (sidx_w),
        .sum          (sum_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.lea  = lea_mode;
            st_d.addr = sum_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_addr    = st_q.addr;
    assign out_mem_req = st_q.valid & ~st_q.lea;
    assign out_reg_wr  = st_q.valid &  st_q.lea;

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          has_base,
    input logic          has_index,
    input logic [1:0]    disp_size,
    input logic          lea_mode,
    input logic          out_valid,
    input logic [AW-1:0] out_addr,
    input logic          out_mem_req,
    input logic          out_reg_wr
);

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_mem_req && !out_reg_wr));

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_bubble_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_absent_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !has_base && !has_index && disp_size == 2'b00) |=> (out_addr == '0));

    assert_lea_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lea_mode) |=> (out_reg_wr && !out_mem_req));

    assert_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !lea_mode) |=> (out_mem_req && !out_reg_wr));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_addr));

endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .has_base    (has_base),
    .has_index   (has_index),
    .disp_size   (disp_size),
    .lea_mode    (lea_mode),
    .out_valid   (out_valid),
    .out_addr    (out_addr),
    .out_mem_req (out_mem_req),
    .out_reg_wr  (out_reg_wr)
);

// File: tb/sim_ea_gen.sv
`timescale 1ns/1ps
module sim_ea_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        has_base = 1'b0;
    logic [31:0] base_val = '0;
    logic        has_index = 1'b0;
    logic [31:0] index_val = '0;
    logic [1:0]  scale_code = '0;
    logic [31:0] disp_raw = '0;
    logic [1:0]  disp_size = '0;
    logic        lea_mode = 1'b0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic        out_mem_req;
    logic        out_reg_wr;

    int unsigned n_run  = 0;
    int unsigned n_fail = 0;
    bit          done   = 0;

    always #2.5 clk = ~clk;

    ea_gen u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .has_base(has_base), .base_val(base_val),
        .has_index(has_index), .index_val(index_val),
        .scale_code(scale_code), .disp_raw(disp_raw), .disp_size(disp_size),
        .lea_mode(lea_mode), .out_valid(out_valid), .out_addr(out_addr),
        .out_mem_req(out_mem_req), .out_reg_wr(out_reg_wr)
    );

    typedef struct packed {
        logic [31:0] base;
        logic        hb;
        logic [31:0] idx;
        logic        hi;
        logic [1:0]  sc;
        logic [31:0] disp;
        logic [1:0]  ds;
        logic        lea;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{32'h0,        1'b0, 32'h0,        1'b0, 2'd0, 32'h0000_8000, 2'd3, 1'b0, 32'h0000_8000}, // absolute R3 R5
        '{32'h8000,     1'b1, 32'h0,        1'b0, 2'd0, 32'h0,         2'd0, 1'b0, 32'h0000_8000}, // indirect
        '{32'h8000,     1'b1, 32'h0,        1'b0, 2'd0, 32'h08,        2'd1, 1'b0, 32'h0000_8008}, // base+disp
        '{32'h8000,     1'b1, 32'h8,        1'b1, 2'd0, 32'h04,        2'd1, 1'b0, 32'h0000_800C}, // indexed x1 R4
        '{32'h8000,     1'b1, 32'h3,        1'b1, 2'd2, 32'h08,        2'd1, 1'b0, 32'h0000_8014}, // x4 R4
        '{32'h0,        1'b0, 32'h1,        1'b1, 2'd2, 32'h0000_00FC, 2'd2, 1'b0, 32'h0000_0100}, // no base R6
        '{32'h100,      1'b1, 32'h0,        1'b0, 2'd0, 32'h0000_00FC, 2'd1, 1'b0, 32'h0000_00FC}, // byte -4 R5
        '{32'h5,        1'b1, 32'h5,        1'b1, 2'd3, 32'h07,        2'd1, 1'b1, 32'h0000_0034}, // 9x+7 lea R7
        '{32'hFFFF_FFF0,1'b1, 32'h0,        1'b0, 2'd0, 32'h20,        2'd1, 1'b0, 32'h0000_0010}, // wrap R9
        '{32'h0,        1'b0, 32'h8000_0001,1'b1, 2'd1, 32'h0,         2'd0, 1'b0, 32'h0000_0002}, // x2 wrap R9
        '{32'hDEAD,     1'b0, 32'h55,       1'b0, 2'd3, 32'h10,        2'd3, 1'b1, 32'h0000_0010}, // absent ignored R6
        '{32'h40,       1'b1, 32'h0,        1'b0, 2'd0, 32'h0000_1234, 2'd0, 1'b0, 32'h0000_0040}, // no disp R5
        '{32'h0001_0000,1'b1, 32'h0,        1'b0, 2'd0, 32'hABCD_8000, 2'd2, 1'b0, 32'h0000_8000}  // half sign R5
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        in_valid   = 1'b1;
        base_val   = v.base;  has_base  = v.hb;
        index_val  = v.idx;   has_index = v.hi;
        scale_code = v.sc;    disp_raw  = v.disp;
        disp_size  = v.ds;    lea_mode  = v.lea;
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {31'b0, out_valid}, 32'h0);
        chk("R1 addr in reset", out_addr, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {31'b0, out_valid}, 32'h0);
        chk("R1 mem_req after reset", {31'b0, out_mem_req}, 32'h0);
        chk("R1 reg_wr after reset", {31'b0, out_reg_wr}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            chk($sformatf("R3 addr vec %0d", i), out_addr, VEC[i].exp);
            chk($sformatf("R2 valid vec %0d", i), {31'b0, out_valid}, 32'h1);
            chk($sformatf("R7 mem_req vec %0d", i), {31'b0, out_mem_req}, {31'b0, ~VEC[i].lea});
            chk($sformatf("R7 reg_wr vec %0d", i), {31'b0, out_reg_wr}, {31'b0, VEC[i].lea});
        end

        // R8: idle cycle with garbage on the operand inputs keeps the address.
        base_val = 32'h1234_5678; has_base = 1'b1; disp_raw = 32'hFFFF_FFFF; disp_size = 2'd3;
        @(negedge clk);
        chk("R8 addr held", out_addr, 32'h0000_8000);
        chk("R2 valid drops", {31'b0, out_valid}, 32'h0);
        chk("R7 flags low when idle", {30'b0, out_mem_req, out_reg_wr}, 32'h0);

        // R4: every scale code on the same index.
        for (int s = 0; s < 4; s++) begin
            vec_t v;
            v = '{32'h0, 1'b0, 32'h3, 1'b1, 2'(s), 32'h0, 2'd0, 1'b0, 32'h0};
            drive(v);
            chk($sformatf("R4 scale code %0d", s), out_addr, 32'h3 << s);
        end

        // Back-to-back requests: each result due one cycle after its request.
        @(negedge clk);
        in_valid = 1'b1; has_base = 1'b1; base_val = 32'h100; has_index = 1'b0;
        disp_size = 2'd1; disp_raw = 32'h1; lea_mode = 1'b0;
        @(negedge clk);
        chk("R2 first of pair", out_addr, 32'h101);
        disp_raw = 32'h80; lea_mode = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R5 byte 0x80 negative", out_addr, 32'h80);
        chk("R7 second of pair lea", {31'b0, out_reg_wr}, 32'h1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule